// File: doc/BRIEF.md
# Sticky Event Interrupt Register with Clear-on-Read

This block gathers the events of a superframe-based line transceiver into one 8-bit status byte for a processor. Some events arrive as one-cycle strobes. The others are found by comparing words with a stored copy: two groups of status bits, the raw embedded-operations message and the trinal-validated message. A block-error bit collects near-end and far-end error flags over one superframe and reports them at the next superframe boundary.

Every interrupting bit is sticky. A processor read of the status address returns the byte and clears the sticky bits, except for any bit whose event lands in the same cycle as the read. A second register holds a 7-bit enable mask, and the interrupt output is the OR of the enabled sticky bits. The lowest bit of the status byte is a live copy of a polled status input. It is never latched, has no enable and never raises the interrupt.

Top module: `evt_irq_reg`

## Requirements
- R1: After reset, all sticky bits and all enable bits are 0, `irq_o` is low and `rd_data_o` is 0x00.
- R2: A pulse on `sf_start_i` sets status bit 7.
- R3: A pulse on `hsf_done_i` sets status bit 6.
- R4: Status bit 5 is set on an `sf_start_i` pulse when `ne_blkerr_i` or `fe_blkerr_i` was high in some cycle after the previous `sf_start_i` pulse. An error flag in the same cycle as `sf_start_i` counts toward the next boundary.
- R5: Status bit 4 is set when any bit of the 6-bit `act_stat_i` differs from its value in the previous cycle. The first cycle after reset only captures the group.
- R6: Status bit 3 is set when any bit of the 7-bit `oth_stat_i` differs from its value in the previous cycle. The first cycle after reset only captures the group.
- R7: Status bit 2 is set when `tmsg_vld_i` is high and `tmsg_i` differs from the last value presented with `tmsg_vld_i`. The first such update after reset only captures the message.
- R8: Status bit 1 is set when `msg_vld_i` is high and `msg_i` differs from the last value presented with `msg_vld_i`. The first such update after reset only captures the message.
- R9: A read strobe at address 0 places {bits 7..1, `poll_stat_i`} on `rd_data_o` in the next cycle and clears bits 7..1 in that same cycle. A bit whose event coincides with the read strobe stays set.
- R10: Status bit 0 follows `poll_stat_i` live. A read does not clear it, and it never asserts `irq_o`.
- R11: A write at address 1 loads `wr_data_i[6:0]` as the enables for status bits 7..1. A read at address 1 returns {enables, 0}. A read at address 1 leaves the sticky bits unchanged.
- R12: `irq_o` is high exactly when some status bit among 7..1 is set and its enable is set. It changes in the cycle after the event or the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sf_start_i | input | 1 | Start of received superframe |
| hsf_done_i | input | 1 | Half superframe processed |
| ne_blkerr_i | input | 1 | Near-end block error flag |
| fe_blkerr_i | input | 1 | Far-end block error flag |
| act_stat_i | input | 6 | Activation status group |
| oth_stat_i | input | 7 | Other line-state status group |
| msg_i | input | 8 | Raw operations message |
| msg_vld_i | input | 1 | Raw message update strobe |
| tmsg_i | input | 8 | Trinal-validated message |
| tmsg_vld_i | input | 1 | Validated message update strobe |
| poll_stat_i | input | 1 | Live status for polling |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 2 | Read address (0 status, 1 enable) |
| rd_data_o | output | 8 | Registered read data |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write address (1 enable) |
| wr_data_i | input | 7 | Enable bits for status bits 7..1 |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong stored copy in one of the change detectors shows up as a bit that sets falsely, or fails to set, on the next update. The read at the following cycle exposes it. A sticky bit that drops without a clear, or is cleared along with a coinciding event, shows up at the very next status read. Stale block-error pending state appears as bit 5 on the wrong boundary. An enable or interrupt fault shows on `irq_o` one cycle after the event or write that should change it.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned IRQ_W   = REG_W - 1;
  localparam int unsigned B_SF    = 7;
  localparam int unsigned B_HSF   = 6;
  localparam int unsigned B_BLK   = 5;
  localparam int unsigned B_ACT   = 4;
  localparam int unsigned B_OTH   = 3;
  localparam int unsigned B_TMSG  = 2;
  localparam int unsigned B_MSG   = 1;
  localparam int unsigned A_STAT  = 0;
  localparam int unsigned A_EN    = 1;
endpackage

// File: rtl/evt_chg_det.sv
module evt_chg_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] d_i,
  output logic         evt_o
);
  logic [W-1:0] copy_q, copy_d;
  logic         primed_q, primed_d;

  always_comb begin
    copy_d   = copy_q;
    primed_d = primed_q;
    evt_o    = vld_i && primed_q && (d_i != copy_q);
    if (vld_i) begin
      copy_d   = d_i;
      primed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      copy_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      copy_q   <= copy_d;
      primed_q <= primed_d;
    end
  end

  // R5 R6 R7 R8: the stored copy tracks every accepted update
  a_r8_copy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> (copy_q == $past(d_i)));
  // R7: first update after reset is silent
  a_r7_silent_until_primed: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> primed_q);
endmodule

// File: rtl/evt_blkerr.sv
module evt_blkerr (
  input  logic clk,
  input  logic rst_n,
  input  logic sf_start_i,
  input  logic ne_i,
  input  logic fe_i,
  output logic evt_o
);
  logic pend_q, pend_d, err;

  always_comb begin
    err    = ne_i | fe_i;
    evt_o  = sf_start_i & pend_q;
    pend_d = pend_q | err;
    if (sf_start_i) pend_d = err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  // R4: each boundary restarts collection with only that cycle's flags
  a_r4_pend_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sf_start_i |=> (pend_q == $past(ne_i | fe_i)));
  a_r4_only_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> sf_start_i);
endmodule

// File: rtl/evt_sticky.sv
module evt_sticky #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (clr_i) q_d = '0;
    q_d = q_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end

  // R9: an event is never lost, even when it meets a clear
  a_r9_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_o & $past(set_i)) == $past(set_i)));
  // R9: bits stay set without a clear
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((q_o & $past(q_o)) == $past(q_o)));
endmodule

// File: rtl/evt_irq_reg.sv
module evt_irq_reg
  import evt_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned ACT_W  = 6,
  parameter int unsigned OTH_W  = 7,
  parameter int unsigned MSG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sf_start_i,
  input  logic              hsf_done_i,
  input  logic              ne_blkerr_i,
  input  logic              fe_blkerr_i,
  input  logic [ACT_W-1:0]  act_stat_i,
  input  logic [OTH_W-1:0]  oth_stat_i,
  input  logic [MSG_W-1:0]  msg_i,
  input  logic              msg_vld_i,
  input  logic [MSG_W-1:0]  tmsg_i,
  input  logic              tmsg_vld_i,
  input  logic              poll_stat_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [IRQ_W-1:0]  wr_data_i,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] STAT_ADR = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] EN_ADR   = ADDR_W'(A_EN);

  logic [REG_W-1:1] set_vec;
  logic [REG_W-1:1] stat_q;
  logic [REG_W-1:1] en_q, en_d;
  logic [REG_W-1:0] rd_d;
  logic             rd_stat, evt_act, evt_oth, evt_tmsg, evt_msg, evt_blk;

  evt_blkerr i_blk (
    .clk(clk), .rst_n(rst_n), .sf_start_i(sf_start_i),
    .ne_i(ne_blkerr_i), .fe_i(fe_blkerr_i), .evt_o(evt_blk)
  );

  evt_chg_det #(.W(ACT_W)) i_act (
    .clk(clk), .rst_n(rst_n), .vld_i(1'b1), .d_i(act_stat_i), .evt_o(evt_act)
  );
  evt_chg_det #(.W(OTH_W)) i_oth (
    .clk(clk), .rst_n(rst_n), .vld_i(1'b1), .d_i(oth_stat_i), .evt_o(evt_oth)
  );
  evt_chg_det #(.W(MSG_W)) i_tmsg (
    .clk(clk), .rst_n(rst_n), .vld_i(tmsg_vld_i), .d_i(tmsg_i), .evt_o(evt_tmsg)
  );
  evt_chg_det #(.W(MSG_W)) i_msg (
    .clk(clk), .rst_n(rst_n), .vld_i(msg_vld_i), .d_i(msg_i), .evt_o(evt_msg)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_SF]   = sf_start_i;
    set_vec[B_HSF]  = hsf_done_i;
    set_vec[B_BLK]  = evt_blk;
    set_vec[B_ACT]  = evt_act;
    set_vec[B_OTH]  = evt_oth;
    set_vec[B_TMSG] = evt_tmsg;
    set_vec[B_MSG]  = evt_msg;
  end

  assign rd_stat = rd_en_i && (rd_addr_i == STAT_ADR);

  evt_sticky #(.W(IRQ_W)) i_stk (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(rd_stat), .q_o(stat_q)
  );

  always_comb begin
    en_d = en_q;
    if (wr_en_i && (wr_addr_i == EN_ADR)) en_d = wr_data_i;
    rd_d = rd_data_o;
    if (rd_en_i) begin
      if (rd_addr_i == STAT_ADR)    rd_d = {stat_q, poll_stat_i};
      else if (rd_addr_i == EN_ADR) rd_d = {en_q, 1'b0};
      else                          rd_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      rd_data_o <= '0;
    end else begin
      en_q      <= en_d;
      rd_data_o <= rd_d;
    end
  end

  assign irq_o = |(stat_q & en_q);

  // R9: a status read with no coinciding event leaves every sticky bit clear
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && (set_vec == '0)) |=> (stat_q == '0));
  // R10: the poll bit alone never raises the interrupt
  a_r10_poll_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |-> !irq_o);
  // R11: an enable-register read keeps the sticky bits
  a_r11_en_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && (rd_addr_i == EN_ADR)) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R12: interrupt only moves after state moves
  a_r12_irq_tracks_state: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(stat_q) && $stable(en_q)) |-> $stable(irq_o));
  // R2: superframe start is seen in the sticky byte
  a_r2_sf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sf_start_i |=> stat_q[B_SF]);
endmodule

// File: tb/test_evt_irq_reg.sv
module test_evt_irq_reg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sf_start_i, hsf_done_i, ne_blkerr_i, fe_blkerr_i;
  logic [5:0] act_stat_i;
  logic [6:0] oth_stat_i;
  logic [7:0] msg_i, tmsg_i;
  logic       msg_vld_i, tmsg_vld_i, poll_stat_i;
  logic       rd_en_i, wr_en_i;
  logic [1:0] rd_addr_i, wr_addr_i;
  logic [7:0] rd_data_o;
  logic [6:0] wr_data_i;
  logic       irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic rd_seen;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  evt_irq_reg i_evt_irq_reg (
    .clk(clk), .rst_n(rst_n), .sf_start_i(sf_start_i), .hsf_done_i(hsf_done_i),
    .ne_blkerr_i(ne_blkerr_i), .fe_blkerr_i(fe_blkerr_i),
    .act_stat_i(act_stat_i), .oth_stat_i(oth_stat_i),
    .msg_i(msg_i), .msg_vld_i(msg_vld_i), .tmsg_i(tmsg_i), .tmsg_vld_i(tmsg_vld_i),
    .poll_stat_i(poll_stat_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: result of a read appears the cycle after the strobe
  always @(posedge clk) rd_seen <= rst_n && rd_en_i;
  always @(negedge clk) begin
    if (rd_seen === 1'b1) begin
      if (exp_q.size() == 0) check("R9 unexpected read", rd_data_o, 8'hxx);
      else check(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
    end
  end

  task automatic do_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en_i = 1'b1; rd_addr_i = a;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_sf();
    sf_start_i = 1'b1; @(negedge clk); sf_start_i = 1'b0;
  endtask

  task automatic wr_en(input logic [6:0] d);
    wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    sf_start_i = 0; hsf_done_i = 0; ne_blkerr_i = 0; fe_blkerr_i = 0;
    act_stat_i = 6'h15; oth_stat_i = 7'h2A; msg_i = 0; tmsg_i = 0;
    msg_vld_i = 0; tmsg_vld_i = 0; poll_stat_i = 0;
    rd_en_i = 0; rd_addr_i = 0; wr_en_i = 0; wr_addr_i = 0; wr_data_i = 0;
    idle(3);
    check("R1 rd_data reset", rd_data_o, 8'h00);
    check("R1 irq reset", {7'd0, irq_o}, 8'h00);
    rst_n = 1'b1;
    idle(2);
    do_read(2'd0, 8'h00, "R1 status after reset");
    do_read(2'd1, 8'h00, "R1 enables after reset");

    pulse_sf();
    do_read(2'd0, 8'h80, "R2 superframe start");
    do_read(2'd0, 8'h00, "R9 cleared by read");

    hsf_done_i = 1; @(negedge clk); hsf_done_i = 0;
    do_read(2'd0, 8'h40, "R3 half superframe");

    pulse_sf();
    do_read(2'd0, 8'h80, "R4 no error boundary");
    ne_blkerr_i = 1; @(negedge clk); ne_blkerr_i = 0;
    idle(2);
    pulse_sf();
    do_read(2'd0, 8'hA0, "R4 near-end error");
    fe_blkerr_i = 1; pulse_sf(); fe_blkerr_i = 0;
    do_read(2'd0, 8'h80, "R4 error on boundary deferred");
    pulse_sf();
    do_read(2'd0, 8'hA0, "R4 far-end error next boundary");

    act_stat_i = 6'h14; @(negedge clk);
    do_read(2'd0, 8'h10, "R5 activation change");
    idle(2);
    do_read(2'd0, 8'h00, "R5 stable group");

    oth_stat_i = 7'h6A; @(negedge clk);
    do_read(2'd0, 8'h08, "R6 other state change");

    tmsg_i = 8'h3C; tmsg_vld_i = 1; @(negedge clk); tmsg_vld_i = 0;
    do_read(2'd0, 8'h00, "R7 first validated msg silent");
    tmsg_vld_i = 1; @(negedge clk); tmsg_vld_i = 0;
    do_read(2'd0, 8'h00, "R7 same validated msg");
    tmsg_i = 8'h3D; @(negedge clk);
    do_read(2'd0, 8'h00, "R7 change without strobe");
    tmsg_vld_i = 1; @(negedge clk); tmsg_vld_i = 0;
    do_read(2'd0, 8'h04, "R7 new validated msg");

    msg_i = 8'h81; msg_vld_i = 1; @(negedge clk); msg_vld_i = 0;
    do_read(2'd0, 8'h00, "R8 first raw msg silent");
    msg_i = 8'h18; msg_vld_i = 1; @(negedge clk); msg_vld_i = 0;
    do_read(2'd0, 8'h02, "R8 new raw msg");

    poll_stat_i = 1; @(negedge clk);
    do_read(2'd0, 8'h01, "R10 poll bit live");
    do_read(2'd0, 8'h01, "R10 poll bit not cleared");
    wr_en(7'h7F);
    check("R10 poll no irq", {7'd0, irq_o}, 8'h00);
    poll_stat_i = 0;

    do_read(2'd1, 8'hFE, "R11 enable readback");
    pulse_sf();
    check("R12 irq on enabled event", {7'd0, irq_o}, 8'h01);
    do_read(2'd1, 8'hFE, "R11 enable read again");
    check("R11 enable read keeps irq", {7'd0, irq_o}, 8'h01);
    wr_en(7'h3F);
    check("R12 irq masked", {7'd0, irq_o}, 8'h00);
    do_read(2'd0, 8'h80, "R11 status kept after enable read");
    check("R12 irq low after clear", {7'd0, irq_o}, 8'h00);

    hsf_done_i = 1; @(negedge clk); hsf_done_i = 0;
    sf_start_i = 1;
    do_read(2'd0, 8'h40, "R9 read with coinciding event");
    sf_start_i = 0;
    do_read(2'd0, 8'h80, "R9 coinciding event kept");

    idle(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule